// File: doc/BRIEF.md
# Three-Phase Overlevel Event Detector

This block watches three signed phase sample streams, one sample per phase on each cycle that a shared valid strobe is high. It compares the magnitude of every sample with a programmable 24-bit unsigned level. When a magnitude goes above the level, it records a sticky event flag, and it sets one sticky bit per offending phase so that software can tell which phase tripped. An active-low interrupt follows the event flag whenever the interrupt enable is set. Two level codes are handled specially. A level of zero raises an event on every valid sample. The full-scale filtered code 0x5A7540 never raises one.

Software acknowledges through two write-one-to-clear strobes, one for the status word and one for the phase-status word. Each word clears independently of the other. The event flag sits at bit 17 of the status word and the phase bits sit at bits [5:3] of the phase-status word, because neighbouring logic decodes those positions. Detecting overvoltage and overcurrent takes two instances of this block.

Top module: `ovl_detect`

## Requirements
- R1: On a valid cycle, a phase whose sample magnitude is strictly greater than the level sets the event flag (status bit 17) and the bit for that phase (phase-status bit 3 for phase A, bit 4 for B, bit 5 for C). Both are visible after the next rising clock edge.
- R2: A magnitude equal to or below a nonzero level sets nothing.
- R3: A level of zero flags all three phases and the event on every valid sample, including samples of value zero.
- R4: The level code 0x5A7540 never raises an event, for any sample value.
- R5: The magnitude of the most negative sample code saturates to the largest positive code (0x7FFFFF for 24-bit samples).
- R6: A sample presented while the valid strobe is low has no effect.
- R7: The event flag is sticky until it is cleared. All other bits of the status word read zero.
- R8: Phase bits accumulate across events and stay set until they are cleared. All other bits of the phase-status word read zero.
- R9: A status write with bit 17 set clears the event flag. A status write with bit 17 clear has no effect. Neither kind of status write changes the phase bits.
- R10: A phase-status write clears each of bits [5:3] that is written as 1 and leaves the others, including the event flag, unchanged.
- R11: `irq_n` is low exactly when the interrupt enable is high and the event flag is set.
- R12: When a new event and a clearing write fall in the same cycle, the flag or phase bit stays set.
- R13: `lvl_rd` returns the level as a 32-bit word whose upper 8 bits are zero.
- R14: After reset, both status words are zero and `irq_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Samples valid this cycle |
| smp_a | input | 24 | Phase A signed sample |
| smp_b | input | 24 | Phase B signed sample |
| smp_c | input | 24 | Phase C signed sample |
| lvl | input | 24 | Unsigned detection level |
| irq_en | input | 1 | Interrupt enable (mask bit) |
| stat_wr | input | 1 | Status word write strobe |
| stat_wdata | input | 32 | Status write data, write-one-to-clear |
| phst_wr | input | 1 | Phase-status write strobe |
| phst_wdata | input | 8 | Phase-status write data, write-one-to-clear |
| stat_word | output | 32 | Status word, event at bit 17 |
| phst_word | output | 8 | Phase-status word, phases at bits [5:3] |
| lvl_rd | output | 32 | Level readback, zero-padded |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Two functions can coincide in one cycle: a new detection and a clearing write to the same flag or phase bit. The bench provokes this on purpose with directed steps that pair a clearing write with an over-level sample. Constrained random runs also provoke it, because they mix clear strobes with samples chosen near the level. A reference model in the bench gives a new detection priority over the clear, and the model is compared with both status words and the interrupt after every edge.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
   localparam int          NPH     = 3;
   localparam logic [23:0] FS_CODE = 24'h5A7540;
   typedef logic [NPH-1:0] ph_vec_t;
endpackage

// File: rtl/ovl_mag.sv
module ovl_mag #(
   parameter int SMP_W   = 24,
   parameter bit SAT_MIN = 1'b1
) (
   input  logic signed [SMP_W-1:0] smp,
   output logic        [SMP_W-2:0] mag
);
   localparam logic [SMP_W-1:0] MIN_CODE = {1'b1, {(SMP_W-1){1'b0}}};

   logic [SMP_W-1:0] neg;
   assign neg = (~smp) + 1'b1;

   generate
      if (SAT_MIN) begin : g_sat
         always_comb begin
            if (smp == MIN_CODE)  mag = '1;
            else if (smp[SMP_W-1]) mag = neg[SMP_W-2:0];
            else                  mag = smp[SMP_W-2:0];
         end
         always_comb
            if (smp == MIN_CODE) assert_sat_R5: assert (&mag);
      end else begin : g_wrap
         always_comb mag = smp[SMP_W-1] ? neg[SMP_W-2:0] : smp[SMP_W-2:0];
      end
   endgenerate
endmodule

// File: rtl/ovl_cmp.sv
module ovl_cmp
   import ovl_pkg::*;
#(
   parameter int MAG_W = 23,
   parameter int LVL_W = 24
) (
   input  logic                   vld,
   input  logic [NPH*MAG_W-1:0]   mag_flat,
   input  logic [LVL_W-1:0]       lvl,
   output ph_vec_t                hit
);
   localparam int CW = (MAG_W > LVL_W) ? MAG_W : LVL_W;
   localparam logic [LVL_W-1:0] FS_L = LVL_W'(FS_CODE);

   logic lvl_zero, lvl_full;
   assign lvl_zero = (lvl == '0);
   assign lvl_full = (lvl == FS_L);

   generate
      for (genvar i = 0; i < NPH; i++) begin : g_ph
         logic [CW-1:0] m_ext, l_ext;
         assign m_ext = CW'(mag_flat[i*MAG_W +: MAG_W]);
         assign l_ext = CW'(lvl);
         assign hit[i] = vld & (lvl_zero | (~lvl_full & (m_ext > l_ext)));
      end
   endgenerate

   always_comb begin
      if (vld && lvl_zero) assert_zero_R3: assert (&hit);
      if (lvl_full)        assert_full_R4: assert (hit == '0);
      if (!vld)            assert_vld_R6:  assert (hit == '0);
   end
endmodule

// File: rtl/ovl_flags.sv
module ovl_flags
   import ovl_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  ph_vec_t hit,
   input  logic    evt_clr,
   input  ph_vec_t ph_clr,
   input  logic    irq_en,
   output logic    evt,
   output ph_vec_t ph,
   output logic    irq_n
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt <= 1'b0;
         ph  <= '0;
      end else begin
         evt <= (evt & ~evt_clr) | (|hit);
         ph  <= (ph & ~ph_clr) | hit;
      end
   end

   assign irq_n = ~(irq_en & evt);

   assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && !evt_clr) |=> evt);
   assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_clr && hit == '0) |=> !evt);
   assert_race_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_clr && hit != '0) |=> evt);
   assert_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> irq_n);

   generate
      for (genvar i = 0; i < NPH; i++) begin : g_chk
         assert_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (ph[i] && !ph_clr[i]) |=> ph[i]);
         assert_phclr_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (ph_clr[i] && !hit[i]) |=> !ph[i]);
      end
   endgenerate
endmodule

// File: rtl/ovl_detect.sv
module ovl_detect
   import ovl_pkg::*;
#(
   parameter int SMP_W   = 24,
   parameter int LVL_W   = 24,
   parameter int STAT_W  = 32,
   parameter int PHST_W  = 8,
   parameter int EVT_BIT = 17,
   parameter int PH_LSB  = 3,
   parameter bit SAT_MIN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_vld,
   input  logic [SMP_W-1:0]  smp_a,
   input  logic [SMP_W-1:0]  smp_b,
   input  logic [SMP_W-1:0]  smp_c,
   input  logic [LVL_W-1:0]  lvl,
   input  logic              irq_en,
   input  logic              stat_wr,
   input  logic [STAT_W-1:0] stat_wdata,
   input  logic              phst_wr,
   input  logic [PHST_W-1:0] phst_wdata,
   output logic [STAT_W-1:0] stat_word,
   output logic [PHST_W-1:0] phst_word,
   output logic [STAT_W-1:0] lvl_rd,
   output logic              irq_n
);
   localparam int MAG_W = SMP_W - 1;

   generate
      if (SMP_W < 2)               begin : g_e0 $error("SMP_W too small"); end
      if (LVL_W > STAT_W)          begin : g_e1 $error("LVL_W exceeds word"); end
      if (EVT_BIT >= STAT_W)       begin : g_e2 $error("EVT_BIT out of word"); end
      if (PH_LSB + NPH > PHST_W)   begin : g_e3 $error("phase field out of word"); end
   endgenerate

   logic [NPH*SMP_W-1:0] smp_flat;
   logic [NPH*MAG_W-1:0] mag_flat;
   ph_vec_t hit, ph, ph_clr;
   logic    evt, evt_clr;

   assign smp_flat = {smp_c, smp_b, smp_a};

   generate
      for (genvar i = 0; i < NPH; i++) begin : g_mag
         ovl_mag #(.SMP_W(SMP_W), .SAT_MIN(SAT_MIN)) u_mag (
            .smp (smp_flat[i*SMP_W +: SMP_W]),
            .mag (mag_flat[i*MAG_W +: MAG_W])
         );
      end
   endgenerate

   ovl_cmp #(.MAG_W(MAG_W), .LVL_W(LVL_W)) u_cmp (
      .vld      (smp_vld),
      .mag_flat (mag_flat),
      .lvl      (lvl),
      .hit      (hit)
   );

   assign evt_clr = stat_wr & stat_wdata[EVT_BIT];
   assign ph_clr  = phst_wr ? phst_wdata[PH_LSB +: NPH] : '0;

   ovl_flags u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (hit),
      .evt_clr (evt_clr),
      .ph_clr  (ph_clr),
      .irq_en  (irq_en),
      .evt     (evt),
      .ph      (ph),
      .irq_n   (irq_n)
   );

   always_comb begin
      stat_word          = '0;
      stat_word[EVT_BIT] = evt;
      phst_word                 = '0;
      phst_word[PH_LSB +: NPH]  = ph;
   end

   assign lvl_rd = STAT_W'(lvl);
endmodule

// File: tb/ovl_detect_bench.sv
module ovl_detect_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_vld = 1'b0;
   logic [23:0] smp_a = '0, smp_b = '0, smp_c = '0, lvl = '0;
   logic        irq_en = 1'b0, stat_wr = 1'b0, phst_wr = 1'b0;
   logic [31:0] stat_wdata = '0;
   logic [7:0]  phst_wdata = '0;
   logic [31:0] stat_word, lvl_rd;
   logic [7:0]  phst_word;
   logic        irq_n;

   int checks = 0, failures = 0;
   bit done = 1'b0;
   logic       m_evt = 1'b0;
   logic [2:0] m_ph = '0;

   localparam logic [23:0] FS = 24'h5A7540;

   always #10 clk = ~clk;

   ovl_detect u_ovl_detect (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
      .smp_a(smp_a), .smp_b(smp_b), .smp_c(smp_c), .lvl(lvl),
      .irq_en(irq_en), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
      .phst_wr(phst_wr), .phst_wdata(phst_wdata),
      .stat_word(stat_word), .phst_word(phst_word), .lvl_rd(lvl_rd),
      .irq_n(irq_n)
   );

   function automatic logic hitf(input logic [23:0] s, input logic [23:0] l);
      logic [23:0] m;
      if (s == 24'h800000)  m = 24'h7FFFFF;
      else if (s[23])       m = -s;
      else                  m = s;
      return (l == 0) || (l != FS && m > l);
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(input logic v, input logic [23:0] a, b, c, l,
                       input logic sw, input logic [31:0] sd,
                       input logic pw, input logic [7:0] pd,
                       input logic en, input string tag);
      logic [2:0] h;
      logic ec;
      logic [31:0] es;
      logic [7:0]  ep;
      @(negedge clk);
      smp_vld = v; smp_a = a; smp_b = b; smp_c = c; lvl = l;
      stat_wr = sw; stat_wdata = sd; phst_wr = pw; phst_wdata = pd; irq_en = en;
      h  = v ? {hitf(c, l), hitf(b, l), hitf(a, l)} : 3'b000;
      ec = sw & sd[17];
      @(posedge clk);
      m_evt = (m_evt & ~ec) | (|h);
      m_ph  = (m_ph & ~(pw ? pd[5:3] : 3'b000)) | h;
      @(negedge clk);
      es = 32'(m_evt) << 17;
      ep = 8'(m_ph) << 3;
      chk(stat_word == es, {tag, " stat_word"}, stat_word, es);
      chk(phst_word == ep, {tag, " phst_word"}, 32'(phst_word), 32'(ep));
      chk(irq_n == !(en & m_evt), {tag, " irq_n"}, 32'(irq_n), 32'(!(en & m_evt)));
      smp_vld = 1'b0; stat_wr = 1'b0; phst_wr = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      chk(stat_word == 0, "R14 reset stat", stat_word, 0);
      chk(phst_word == 0, "R14 reset phst", 32'(phst_word), 0);
      chk(irq_n == 1'b1, "R14 reset irq", 32'(irq_n), 1);
      rst_n = 1'b1;

      step(1, 24'd1001, 24'd5, 24'd0, 24'd1000, 0, 0, 0, 0, 1, "R1 A over");
      step(1, -24'd1000, 24'd1000, -24'd999, 24'd1000, 0, 0, 0, 0, 1, "R2 equal");
      step(1, 0, -24'd1001, 0, 24'd1000, 0, 0, 0, 0, 1, "R8 accumulate B");
      step(0, 24'd9, 24'd9, 24'd9, 24'd0, 1, 32'hFFFD_FFFF, 0, 0, 1, "R9 no-bit17 write");
      step(0, 0, 0, 0, 24'd1000, 1, 32'h0002_0000, 0, 0, 1, "R9 clear");
      step(0, 0, 0, 0, 24'd1000, 0, 0, 1, 8'h08, 1, "R10 clear A only");
      step(0, 24'd5000, 0, 0, 24'd0, 0, 0, 0, 0, 1, "R6 invalid ignored");
      step(1, 0, 0, 0, 24'd0, 0, 0, 0, 0, 0, "R3 zero level");
      step(0, 0, 0, 0, 24'd0, 0, 0, 0, 0, 1, "R11 mask on");
      step(1, 24'd1, 24'd1, 24'd1, 24'd0, 1, 32'h0002_0000, 1, 8'h38, 1, "R12 race");
      step(0, 0, 0, 0, 24'd0, 1, 32'h0002_0000, 1, 8'h38, 1, "R9 R10 clear all");
      step(1, 24'h7FFFFF, 24'h800000, 24'h800001, FS, 0, 0, 0, 0, 1, "R4 full scale");
      step(1, 24'h800000, 0, 0, 24'h7FFFFE, 0, 0, 0, 0, 1, "R5 min saturates over");
      step(0, 0, 0, 0, 0, 1, 32'h0002_0000, 1, 8'h38, 1, "R9 clear");
      step(1, 24'h800000, 0, 0, 24'h7FFFFF, 0, 0, 0, 0, 1, "R5 min equals max");
      @(negedge clk);
      lvl = 24'hABCDEF;
      #1 chk(lvl_rd == 32'h00AB_CDEF, "R13 readback", lvl_rd, 32'h00AB_CDEF);

      for (int n = 0; n < 600; n++) begin
         logic [23:0] l, s [3];
         int k;
         k = $urandom_range(0, 9);
         if (k == 0)      l = 0;
         else if (k == 1) l = FS;
         else if (k < 6)  l = 24'($urandom_range(0, 4000));
         else             l = 24'($urandom);
         for (int p = 0; p < 3; p++) begin
            int q;
            q = $urandom_range(0, 4);
            if (q == 0)      s[p] = l + 24'($urandom_range(0, 2)) - 24'd1;
            else if (q == 1) s[p] = -(l + 24'($urandom_range(0, 2)) - 24'd1);
            else if (q == 2) s[p] = 24'h800000;
            else             s[p] = 24'($urandom);
         end
         step(1'($urandom), s[0], s[1], s[2], l,
              ($urandom_range(0, 3) == 0), $urandom,
              ($urandom_range(0, 3) == 0), 8'($urandom),
              1'($urandom), "R1 R7 R8 R9 R10 R11 R12 random");
      end

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule